// File: doc/BRIEF.md
# Prescaled Reloading Overflow Timer

This block is a free-running up-counter with a configurable clock divider in front of it. Software supplies a start value. The counter climbs from that value to the all-ones state. On the step past all-ones it reloads the start value and emits a one-cycle interrupt pulse. The time between interrupts is therefore set by both the start value and the divider ratio. The divider ratio is either one, when the divider is switched off, or a power of two from 2 to 256, chosen by a 3-bit exponent.

A debug halt pin lets a debugger stop the timer. The pin is asynchronous and active-low. It is resynchronised into the timer clock domain before use. When the free-run bit is clear, an asserted halt freezes both the divider and the counter. When the halt is released, counting continues exactly where it stopped. When the free-run bit is set, the pin has no effect.

Top module: `prescaled_overflow_timer`

## Requirements
- R1: With `divEn` = 0 the counter steps on every clock, whatever value `divExp` holds.
- R2: With `divEn` = 1 the counter steps once every 2^(`divExp`+1) clocks, giving 2, 4, 8, 16, 32, 64, 128 or 256 for `divExp` 0 to 7.
- R3: Consecutive interrupts are (2^32 − `startVal`) × divisor clocks apart. For example, a start value of 0xFFFFFFFE with divisor 1 gives a period of 2, and 0xFFFFFFF0 gives 16.
- R4: On overflow, `count` takes `startVal` on the same edge, and `ovfIrq` is high for that single cycle.
- R5: The clock edge that first samples `runEn` = 1 loads `startVal` into `count` and clears the divider. While `runEn` = 0, `count` holds and `ovfIrq` stays low.
- R6: With `freeRun` = 1, the level on `suspendN` changes neither the counting nor the interrupt timing.
- R7: With `freeRun` = 0 and the synchronised `suspendN` low, both the divider and the counter hold their state. After release, counting resumes from the held state, so holding the pin low for L clock edges delays the next interrupt by exactly L clocks.
- R8: `suspendN` passes through a two-flop synchroniser. The counter still advances on the two edges that first sample the pin low, and it halts from the third edge on.
- R9: Any change of `divEn` or `divExp` clears the divider count on the edge that first sees the new setting. That edge produces no step, and the new ratio is counted from zero.
- R10: While reset is asserted, `count` is 0 and `ovfIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Timer run enable |
| divEn | input | 1 | Divider enable |
| divExp | input | 3 | Divider exponent; ratio is 2^(divExp+1) |
| startVal | input | 32 | Value loaded on start and on each overflow |
| freeRun | input | 1 | 1: ignore the debug halt pin |
| suspendN | input | 1 | Asynchronous debug halt, active low |
| ovfIrq | output | 1 | One-cycle overflow interrupt pulse |
| count | output | 32 | Current counter value |

## Verification
On every cycle, the assertions check three things. The counter reloads the start value whenever the interrupt fires. The counter never moves without a step or load strobe. No interrupt appears while the timer is off, and the counter stays still once a halt has passed the synchroniser. Exact interrupt periods across all sixteen divider settings can only be shown by the bench's scenarios. The same holds for the one extra clock of latency per halted edge, for the two-edge synchroniser delay, and for the divider restart after a ratio change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Strobes from control to datapath, valid for the coming clock edge.
  typedef struct packed {
    logic load;   // take the start value (timer just switched on)
    logic tick;   // one divided step
  } tmrStrobes_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             divEn,
  input  logic [EXP_W-1:0] divExp,
  input  logic             freeRun,
  input  logic             suspendN,
  output tmrStrobes_t      strobes
);
  localparam int PS_W  = 1 << EXP_W;   // wide enough for the largest ratio minus one
  localparam int CFG_W = EXP_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   enPrev;
  logic [CFG_W-1:0]       cfgPrev;
  logic [PS_W-1:0]        psCnt;
  logic [PS_W-1:0]        psLimit;
  logic                   suspSync;
  logic                   frozen;
  logic                   active;
  logic                   cfgChange;

  // Halt pin resynchroniser, idles high (not halted).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], suspendN};
  end

  assign suspSync  = syncQ[SYNC_STAGES-1];
  assign frozen    = !freeRun && !suspSync;
  assign cfgChange = ({divEn, divExp} != cfgPrev);
  assign active    = runEn && enPrev && !frozen;

  // Terminal count of the divider: ratio minus one, or zero when bypassed.
  assign psLimit = divEn ? (((PS_W'(1) << divExp) << 1) - PS_W'(1)) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      cfgPrev <= '0;
      psCnt   <= '0;
    end else begin
      enPrev  <= runEn;
      cfgPrev <= {divEn, divExp};
      if (strobes.load || cfgChange) psCnt <= '0;
      else if (active)               psCnt <= (psCnt == psLimit) ? '0 : psCnt + PS_W'(1);
    end
  end

  always_comb begin
    strobes.load = runEn && !enPrev;
    strobes.tick = active && !cfgChange && (psCnt == psLimit);
  end

  // R5: with the timer off, the datapath receives no strobes
  a_r5_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (!strobes.tick && !strobes.load));

  // R9: the edge that sees a new ratio produces no step
  a_r9_cfg_restart: assert property (@(posedge clk) disable iff (!rstN)
    ({divEn, divExp} != $past({divEn, divExp})) && $past(rstN) |-> !strobes.tick);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  input  logic [CNT_W-1:0] startVal,
  output logic [CNT_W-1:0] countQ,
  output logic             ovfIrq
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      ovfIrq <= 1'b0;
    end else begin
      ovfIrq <= 1'b0;
      if (strobes.load) begin
        countQ <= startVal;
      end else if (strobes.tick) begin
        if (countQ == ALL_ONES) begin
          countQ <= startVal;
          ovfIrq <= 1'b1;
        end else begin
          countQ <= countQ + CNT_W'(1);
        end
      end
    end
  end

  // R4: an interrupt cycle always shows the freshly reloaded start value
  a_r4_reload_on_irq: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> countQ == $past(startVal));

  // R7: without a strobe from control the counter keeps its value
  a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.load) |=> $stable(countQ));
endmodule

// File: rtl/prescaled_overflow_timer.sv
module prescaled_overflow_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             divEn,
  input  logic [EXP_W-1:0] divExp,
  input  logic [CNT_W-1:0] startVal,
  input  logic             freeRun,
  input  logic             suspendN,
  output logic             ovfIrq,
  output logic [CNT_W-1:0] count
);
  tmrStrobes_t strobes;

  tmr_ctrl #(.EXP_W(EXP_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .divEn    (divEn),
    .divExp   (divExp),
    .freeRun  (freeRun),
    .suspendN (suspendN),
    .strobes  (strobes)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .startVal (startVal),
    .countQ   (count),
    .ovfIrq   (ovfIrq)
  );

  // R5: an interrupt only follows a cycle in which the timer was on
  a_r5_no_irq_when_off: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> $past(runEn));

  // R8: two sampled-low edges of the halt pin stop the counter on the next edge
  a_r8_sync_then_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!freeRun && runEn && $past(runEn) && $past(rstN) && $past(rstN, 2) &&
     !$past(suspendN) && !$past(suspendN, 2)) |=> $stable(count));
endmodule

// File: tb/test_prescaled_overflow_timer.sv
module test_prescaled_overflow_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        divEn = 1'b0;
  logic [2:0]  divExp = '0;
  logic [31:0] startVal = '0;
  logic        freeRun = 1'b0;
  logic        suspendN = 1'b1;
  logic        ovfIrq;
  logic [31:0] count;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  prescaled_overflow_timer i_prescaled_overflow_timer (
    .clk(clk), .rstN(rstN), .runEn(runEn), .divEn(divEn), .divExp(divExp),
    .startVal(startVal), .freeRun(freeRun), .suspendN(suspendN),
    .ovfIrq(ovfIrq), .count(count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Counts edges until ovfIrq is seen; the edge that shows the pulse is included.
  task automatic waitIrq(output int n);
    n = 0;
    do begin step(); n++; end while (!ovfIrq && n < 5000);
    if (n >= 5000) check(1'b0, "timeout", n, 0);
  endtask

  task automatic startTimer(input logic [31:0] ld, input logic de, input logic [2:0] ex, input logic fr);
    runEn = 1'b0; startVal = ld; divEn = de; divExp = ex; freeRun = fr; suspendN = 1'b1;
    step(); step();
    runEn = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int n, m, d, tot;
    logic [31:0] c0, c2, c4;
    #1;
    // R10: reset state
    check(count == 0, "R10 count", count, 0);
    check(ovfIrq == 0, "R10 irq", ovfIrq, 0);
    step(); rstN = 1'b1; step();

    // R5: enabling loads the start value on the first edge
    startTimer(32'h1234_0000, 1'b0, 3'd0, 1'b0);
    step();
    check(count == 32'h1234_0000, "R5 load", count, 32'h1234_0000);
    step(); step();
    check(count == 32'h1234_0002, "R1 step", count, 32'h1234_0002);
    runEn = 1'b0; step(); c0 = count;
    n = 0;
    repeat (10) begin step(); if (ovfIrq) n++; end
    check(count == c0, "R5 hold off", count, c0);
    check(n == 0, "R5 no irq off", n, 0);

    // R1/R2/R3/R4: sweep every divider setting with three steps per period
    for (int de = 0; de < 2; de++) begin
      for (int e = 0; e < 8; e++) begin
        d = de ? (1 << (e + 1)) : 1;
        startTimer(32'hFFFF_FFFD, de[0], e[2:0], 1'b0);
        waitIrq(n);
        check(n == 3 * d + 1, de ? "R2 first period" : "R1 first period", n, 3 * d + 1);
        check(count == 32'hFFFF_FFFD, "R4 reload", count, 32'hFFFF_FFFD);
        step();
        check(ovfIrq == 0, "R4 single pulse", ovfIrq, 0);
        waitIrq(m);
        check(m + 1 == 3 * d, "R3 period", m + 1, 3 * d);
      end
    end

    // R3: named start values
    startTimer(32'hFFFF_FFFE, 1'b0, 3'd5, 1'b0);
    waitIrq(n); waitIrq(m);
    check(m == 2, "R3 period 2", m, 2);
    startTimer(32'hFFFF_FFF0, 1'b0, 3'd0, 1'b0);
    waitIrq(n); waitIrq(m);
    check(m == 16, "R3 period 16", m, 16);

    // R7 and R6: a halt of 10 edges in the middle of a ratio-8 period
    for (int fr = 0; fr < 2; fr++) begin
      startTimer(32'hFFFF_FFFD, 1'b1, 3'd2, fr[0]);
      waitIrq(n);
      tot = 0;
      repeat (5) begin step(); tot++; end
      suspendN = 1'b0;
      repeat (10) begin step(); tot++; end
      suspendN = 1'b1;
      waitIrq(m);
      tot += m;
      if (fr == 0) check(tot == 34, "R7 halted period", tot, 34);
      else         check(tot == 24, "R6 free-run period", tot, 24);
    end

    // R8 and R7: synchroniser latency, held value, and resume
    startTimer(32'hFFFF_0000, 1'b0, 3'd0, 1'b0);
    repeat (4) step();
    c0 = count;
    suspendN = 1'b0;
    step(); step(); c2 = count;
    step(); step(); c4 = count;
    check(c2 == c0 + 2, "R8 two edges of latency", c2, c0 + 2);
    check(c4 == c0 + 2, "R7 held", c4, c0 + 2);
    suspendN = 1'b1;
    repeat (3) step();
    check(count == c0 + 3, "R7 resume", count, c0 + 3);

    // R9: ratio change from 8 to 4 three edges after an interrupt
    startTimer(32'hFFFF_FFFD, 1'b1, 3'd2, 1'b0);
    waitIrq(n);
    repeat (3) step();
    divExp = 3'd1;
    waitIrq(m);
    check(m + 3 == 16, "R9 divider restart", m + 3, 16);

    runEn = 1'b0;
    step();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule